// File: doc/BRIEF.md
# BCD Calendar Time-Date Counter

The block keeps the time of day and the calendar date in packed BCD fields and moves forward by one second for each calendar tick, a single-cycle pulse at 1 Hz. Seconds, minutes and hours run in 24-hour form. The date side holds the day of the month, the month, a weekday and a two-digit year that stands for 2000 to 2099. Carries ripple from seconds up to the year inside a single clock. Month lengths and leap years are worked out from the current month and year.

Software sets the calendar by raising `init_mode`. While that input is high the counters are frozen and writes of the time word and the date word are accepted. Writes made at any other time are ignored. The bus side reads shadow copies of the two words. A load or an explicit clear drops `shadow_valid`, and the shadows then stay frozen. Once `SYNC_TICKS` calendar ticks have passed outside init mode, the shadows are refreshed and the flag rises again. A status output reports whether the calendar holds a value other than the all-zero reset value, so that start-up code can skip initialisation.

Top module: `bcd_calendar`

## Requirements
- R1: The time word carries seconds as BCD in bits 6:0, minutes as BCD in bits 14:8 and hours as BCD in bits 21:16. Every other bit is 0.
- R2: The date word carries the day of the month as BCD in bits 5:0, the month as BCD in bits 12:8, the weekday (binary, 1 to 7) in bits 15:13 and the year as BCD in bits 23:16. Every other bit is 0.
- R3: On each accepted tick, seconds step and wrap from 59 to 00 with a carry into minutes. Minutes wrap from 59 to 00 with a carry into hours. Hours wrap from 23 to 00 with a carry into the day.
- R4: The day of the month wraps to 01 after 31, or after 30 in months 04, 06, 09 and 11, and carries into the month. In month 02 it wraps after 29 when the year is divisible by 4 (year 00 included) and after 28 otherwise.
- R5: The month wraps from 12 to 01 and increments the year. The year wraps from 99 to 00.
- R6: On each day carry the weekday steps 1 to 7 and then returns to 1. A weekday of 0 stays 0.
- R7: A write of the time word (`wr_time`) or the date word (`wr_date`) from `wr_data` takes effect only while `init_mode` is 1. Outside init mode the write has no effect. While `init_mode` is 1, ticks do not advance the calendar.
- R8: An accepted write or `sync_clear` drops `shadow_valid` at the next edge, and `time_word`/`date_word` then hold. After `SYNC_TICKS` ticks outside init mode (default 2), the following edge refreshes both words and raises `shadow_valid` together. While the flag is 1, both words follow the live counters with one cycle of lag.
- R9: `calendar_set` goes to 1 when an accepted write leaves the time or date non-zero. It goes to 0 when an accepted write leaves both all-zero.
- R10: After reset both words, `shadow_valid` and `calendar_set` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_tick | input | 1 | One-cycle 1 Hz calendar pulse |
| init_mode | input | 1 | Initialisation window: freezes counting, enables writes |
| wr_time | input | 1 | Write strobe for the time word |
| wr_date | input | 1 | Write strobe for the date word |
| wr_data | input | 32 | Write data in time or date word layout |
| sync_clear | input | 1 | Clears the shadow-valid flag |
| time_word | output | 32 | Shadow copy of the time word |
| date_word | output | 32 | Shadow copy of the date word |
| shadow_valid | output | 1 | Shadow copies are current |
| calendar_set | output | 1 | Calendar holds a non-reset value |

## Verification
The hardest state to reach is a chain of carries that runs through every field at once, for example a midnight that is also a month end, a year end or the last day of February in a leap year or a common year. Counting there from reset would take millions of ticks. The stimulus instead writes the calendar a second or two before each such boundary during init mode and then ticks through it. A second hard case is the lag and freeze of the shadow words around a clear. The stimulus clears the flag right after an idle cycle, while the shadows match the live counters, and then steps single ticks so that every frozen and refreshed value is observed.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [5:0] hr;
    logic [6:0] mn;
    logic [6:0] sc;
  } cal_time_t;

  typedef struct packed {
    logic [7:0] yr;
    logic [2:0] wd;
    logic [4:0] mo;
    logic [5:0] dy;
  } cal_date_t;

  // Two-digit BCD increment, low digit 9 rolls into the high digit.
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] == 4'h9) bcd_inc8 = {v[7:4] + 4'h1, 4'h0};
    else                bcd_inc8 = {v[7:4], v[3:0] + 4'h1};
  endfunction

  // BCD year divisible by four: even tens with 0/4/8, odd tens with 2/6.
  function automatic logic year_is_leap(input logic [7:0] y);
    if (y[4]) year_is_leap = (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    else      year_is_leap = (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  endfunction

  function automatic logic [31:0] pack_time(input cal_time_t t);
    pack_time = {10'b0, t.hr, 1'b0, t.mn, 1'b0, t.sc};
  endfunction

  function automatic logic [31:0] pack_date(input cal_date_t d);
    pack_date = {8'b0, d.yr, d.wd, d.mo, 2'b0, d.dy};
  endfunction

  function automatic cal_time_t unpack_time(input logic [31:0] w);
    unpack_time.hr = w[21:16];
    unpack_time.mn = w[14:8];
    unpack_time.sc = w[6:0];
  endfunction

  function automatic cal_date_t unpack_date(input logic [31:0] w);
    unpack_date.yr = w[23:16];
    unpack_date.wd = w[15:13];
    unpack_date.mo = w[12:8];
    unpack_date.dy = w[5:0];
  endfunction

endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
  parameter int W  = 7,
  parameter int LO = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] hi,
  output logic [W-1:0] q,
  output logic         wrap
);
  logic [7:0] ext;
  logic [7:0] bumped;

  always_comb begin
    ext = '0;
    ext[W-1:0] = q;
    bumped = cal_pkg::bcd_inc8(ext);
  end

  assign wrap = inc && (q == hi);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= (q == hi) ? W'(LO) : bumped[W-1:0];
  end

  // R3: a field that is told to step and is not at its limit changes value
  p_field_steps_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && q != hi) |=> (q != $past(q)));

endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              ld,
  input  cal_pkg::cal_time_t ld_val,
  output cal_pkg::cal_time_t cur,
  output logic              day_carry
);
  logic sc_wrap, mn_wrap, hr_wrap;

  cal_bcd_field #(.W(7), .LO(0)) u_sec (
    .clk(clk), .rst(rst), .inc(adv), .ld(ld), .ld_val(ld_val.sc),
    .hi(7'h59), .q(cur.sc), .wrap(sc_wrap));

  cal_bcd_field #(.W(7), .LO(0)) u_min (
    .clk(clk), .rst(rst), .inc(sc_wrap), .ld(ld), .ld_val(ld_val.mn),
    .hi(7'h59), .q(cur.mn), .wrap(mn_wrap));

  cal_bcd_field #(.W(6), .LO(0)) u_hour (
    .clk(clk), .rst(rst), .inc(mn_wrap), .ld(ld), .ld_val(ld_val.hr),
    .hi(6'h23), .q(cur.hr), .wrap(hr_wrap));

  assign day_carry = hr_wrap;

  // R3: last second of the day rolls over to midnight in one edge
  p_midnight_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && !ld && cur.sc == 7'h59 && cur.mn == 7'h59 && cur.hr == 6'h23)
    |=> (cur.sc == 7'h00 && cur.mn == 7'h00 && cur.hr == 6'h00));

  // R7: no step and no load leaves the time fields untouched
  p_time_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!adv && !ld) |=> $stable(cur));

endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              ld,
  input  cal_pkg::cal_date_t ld_val,
  output cal_pkg::cal_date_t cur
);
  import cal_pkg::*;

  logic       dy_wrap, mo_wrap, yr_wrap;
  logic [5:0] dy_hi;

  assign dy_hi = last_day(cur.mo, year_is_leap(cur.yr));

  cal_bcd_field #(.W(6), .LO(1)) u_day (
    .clk(clk), .rst(rst), .inc(adv), .ld(ld), .ld_val(ld_val.dy),
    .hi(dy_hi), .q(cur.dy), .wrap(dy_wrap));

  cal_bcd_field #(.W(5), .LO(1)) u_month (
    .clk(clk), .rst(rst), .inc(dy_wrap), .ld(ld), .ld_val(ld_val.mo),
    .hi(5'h12), .q(cur.mo), .wrap(mo_wrap));

  cal_bcd_field #(.W(8), .LO(0)) u_year (
    .clk(clk), .rst(rst), .inc(mo_wrap), .ld(ld), .ld_val(ld_val.yr),
    .hi(8'h99), .q(cur.yr), .wrap(yr_wrap));

  always_ff @(posedge clk) begin
    if (rst)                          cur.wd <= '0;
    else if (ld)                      cur.wd <= ld_val.wd;
    else if (adv && cur.wd != 3'd0)   cur.wd <= (cur.wd == 3'd7) ? 3'd1 : cur.wd + 3'd1;
  end

  // R4: 28 February of year 00 is followed by the 29th
  p_feb_leap_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && !ld && cur.mo == 5'h02 && cur.dy == 6'h28 && cur.yr == 8'h00)
    |=> (cur.dy == 6'h29 && cur.mo == 5'h02));

  // R5: last day of 2099 rolls into 1 January 2000
  p_year_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && !ld && cur.yr == 8'h99 && cur.mo == 5'h12 && cur.dy == 6'h31)
    |=> (cur.yr == 8'h00 && cur.mo == 5'h01 && cur.dy == 6'h01));

  // R6: invalid weekday is held
  p_wday_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!ld && cur.wd == 3'd0) |=> (cur.wd == 3'd0));

  // R6: weekday 7 returns to 1
  p_wday_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && !ld && cur.wd == 3'd7) |=> (cur.wd == 3'd1));

  // yr_wrap has no consumer above the year; kept as a visible carry
  logic unused_yr_wrap;
  assign unused_yr_wrap = yr_wrap;

endmodule

// File: rtl/cal_shadow_sync.sv
module cal_shadow_sync #(
  parameter int SYNC_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        init_mode,
  input  logic        clr,
  input  logic [31:0] live_t,
  input  logic [31:0] live_d,
  output logic [31:0] sh_t,
  output logic [31:0] sh_d,
  output logic        sync_ok
);
  localparam int CNT_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;

  logic [CNT_W-1:0] cnt;
  logic             pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_t    <= '0;
      sh_d    <= '0;
      sync_ok <= 1'b0;
      pend    <= 1'b0;
      cnt     <= '0;
    end else begin
      if (sync_ok || pend) begin
        sh_t <= live_t;
        sh_d <= live_d;
      end
      if (clr) begin
        sync_ok <= 1'b0;
        pend    <= 1'b0;
        cnt     <= '0;
      end else if (pend) begin
        sync_ok <= 1'b1;
        pend    <= 1'b0;
      end else if (!sync_ok && !init_mode && tick) begin
        if (cnt == CNT_W'(SYNC_TICKS - 1)) begin
          pend <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8: shadows stay frozen while neither valid nor about to refresh
  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (!sync_ok && !pend) |=> ($stable(sh_t) && $stable(sh_d)));

  // R8: the flag only rises out of the refresh step
  p_rise_after_refresh_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_ok) |-> $past(pend));

  // R8: a clear always drops the flag
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !sync_ok);

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int SYNC_TICKS = 2,
  parameter int WORD_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_tick,
  input  logic              init_mode,
  input  logic              wr_time,
  input  logic              wr_date,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              sync_clear,
  output logic [WORD_W-1:0] time_word,
  output logic [WORD_W-1:0] date_word,
  output logic              shadow_valid,
  output logic              calendar_set
);
  import cal_pkg::*;

  logic        acc_t, acc_d, adv;
  logic        day_carry;
  cal_time_t   live_t, load_t;
  cal_date_t   live_d, load_d;
  logic [31:0] live_tw, live_dw, next_tw, next_dw;
  logic [31:0] data32;

  always_comb begin
    data32 = '0;
    data32[((WORD_W < 32) ? WORD_W : 32)-1:0] = wr_data[((WORD_W < 32) ? WORD_W : 32)-1:0];
  end

  assign acc_t  = init_mode && wr_time;
  assign acc_d  = init_mode && wr_date;
  assign adv    = cal_tick && !init_mode;
  assign load_t = unpack_time(data32);
  assign load_d = unpack_date(data32);

  cal_time_chain u_time (
    .clk(clk), .rst(rst), .adv(adv), .ld(acc_t), .ld_val(load_t),
    .cur(live_t), .day_carry(day_carry));

  cal_date_chain u_date (
    .clk(clk), .rst(rst), .adv(day_carry), .ld(acc_d), .ld_val(load_d),
    .cur(live_d));

  assign live_tw = pack_time(live_t);
  assign live_dw = pack_date(live_d);
  assign next_tw = acc_t ? pack_time(load_t) : live_tw;
  assign next_dw = acc_d ? pack_date(load_d) : live_dw;

  always_ff @(posedge clk) begin
    if (rst)                calendar_set <= 1'b0;
    else if (acc_t || acc_d) calendar_set <= |{next_tw, next_dw};
  end

  logic [31:0] sh_t, sh_d;

  cal_shadow_sync #(.SYNC_TICKS(SYNC_TICKS)) u_sync (
    .clk(clk), .rst(rst), .tick(cal_tick), .init_mode(init_mode),
    .clr(sync_clear || acc_t || acc_d), .live_t(live_tw), .live_d(live_dw),
    .sh_t(sh_t), .sh_d(sh_d), .sync_ok(shadow_valid));

  always_comb begin
    time_word = '0;
    date_word = '0;
    time_word[((WORD_W < 32) ? WORD_W : 32)-1:0] = sh_t[((WORD_W < 32) ? WORD_W : 32)-1:0];
    date_word[((WORD_W < 32) ? WORD_W : 32)-1:0] = sh_d[((WORD_W < 32) ? WORD_W : 32)-1:0];
  end

  // R7: writes outside init mode, without a tick, leave the calendar alone
  p_ignore_write_r7: assert property (@(posedge clk) disable iff (rst)
    (!init_mode && !cal_tick && (wr_time || wr_date))
    |=> ($stable(live_tw) && $stable(live_dw)));

  // R7: ticks during init mode do not move the calendar
  p_init_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (init_mode && !wr_time && !wr_date) |=> ($stable(live_tw) && $stable(live_dw)));

  // R9: an accepted all-zero load of both words leaves the status clear
  p_zero_load_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_t && wr_data == '0 && live_dw == 32'd0) |=> !calendar_set);

  // R1: reserved time bits never set on the output
  p_time_reserved_r1: assert property (@(posedge clk) disable iff (rst)
    (time_word[31:22] == 10'd0) && !time_word[15] && !time_word[7]);

endmodule

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cal_tick = 1'b0, init_mode = 1'b0, wr_time = 1'b0, wr_date = 1'b0, sync_clear = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] time_word, date_word;
  logic        shadow_valid, calendar_set;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bcd_calendar uut (
    .clk(clk), .rst(rst), .cal_tick(cal_tick), .init_mode(init_mode),
    .wr_time(wr_time), .wr_date(wr_date), .wr_data(wr_data), .sync_clear(sync_clear),
    .time_word(time_word), .date_word(date_word),
    .shadow_valid(shadow_valid), .calendar_set(calendar_set));

  // Behavioural reference: binary integers, packed only for comparison.
  int ms, mm, mh, md, mo, my, mw, mcnt;
  bit mok, mpend, mset;
  logic [31:0] msht, mshd;

  function automatic int b2(input int v); return (v / 10) * 16 + (v % 10); endfunction
  function automatic int d2(input int v); return (v / 16) * 10 + (v % 16); endfunction

  function automatic logic [31:0] mtw();
    return 32'((b2(mh) << 16) | (b2(mm) << 8) | b2(ms));
  endfunction
  function automatic logic [31:0] mdw();
    return 32'((b2(my) << 16) | (mw << 13) | (b2(mo) << 8) | b2(md));
  endfunction
  function automatic int month_len();
    if (mo == 2) return (my % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    ms = 0; mm = 0; mh = 0; md = 0; mo = 0; my = 0; mw = 0; mcnt = 0;
    mok = 0; mpend = 0; mset = 0; msht = '0; mshd = '0;
  endtask

  task automatic model_second();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          if (md == month_len()) begin
            md = 1;
            if (mo == 12) begin mo = 1; my = (my == 99) ? 0 : my + 1; end
            else mo++;
          end else md++;
          if (mw != 0) mw = (mw == 7) ? 1 : mw + 1;
        end
      end
    end
  endtask

  task automatic model_edge(input bit tk, input bit im, input bit wt, input bit wd,
                            input logic [31:0] dat, input bit clr);
    logic [31:0] t0, d0;
    bit ok0, pend0;
    t0 = mtw(); d0 = mdw(); ok0 = mok; pend0 = mpend;
    if (tk && !im) model_second();
    if (im && wt) begin ms = d2(dat[6:0]); mm = d2(dat[14:8]); mh = d2(dat[21:16]); end
    if (im && wd) begin
      md = d2(dat[5:0]); mo = d2(dat[12:8]); mw = dat[15:13]; my = d2(dat[23:16]);
    end
    if (im && (wt || wd)) mset = (mtw() != 0) || (mdw() != 0);
    if (ok0 || pend0) begin msht = t0; mshd = d0; end
    if (clr || (im && (wt || wd))) begin mok = 0; mpend = 0; mcnt = 0; end
    else if (mpend) begin mok = 1; mpend = 0; end
    else if (!mok && !im && tk) begin
      if (mcnt + 1 == 2) begin mpend = 1; mcnt = 0; end
      else mcnt++;
    end
  endtask

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check_eq("R1 time word", time_word, msht);
    check_eq("R2 date word", date_word, mshd);
    check_eq("R8 shadow_valid", {31'b0, shadow_valid}, {31'b0, mok});
    check_eq("R9 calendar_set", {31'b0, calendar_set}, {31'b0, mset});
  endtask

  // Called at a falling edge; applies inputs for one rising edge.
  task automatic step(input bit tk, input bit im, input bit wt, input bit wd,
                      input logic [31:0] dat, input bit clr);
    cal_tick = tk; init_mode = im; wr_time = wt; wr_date = wd; wr_data = dat; sync_clear = clr;
    @(posedge clk);
    model_edge(tk, im, wt, wd, dat, clr);
    @(negedge clk);
    compare_all();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, '0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, 0);
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] d);
    step(0, 1, 0, 0, '0, 0);
    step(1, 1, 1, 0, t, 0);
    step(0, 1, 0, 1, d, 0);
    step(0, 0, 0, 0, '0, 0);
  endtask

  logic [31:0] hold_t;

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check_eq("R10 reset time", time_word, 32'h0);
    check_eq("R10 reset date", date_word, 32'h0);
    check_eq("R10 reset flags", {30'b0, shadow_valid, calendar_set}, 32'h0);

    // R4 leap February, R6 weekday 7 -> 1, R3 midnight carry
    load(32'h0023_5958, 32'h0000_E228);
    check_eq("R9 set after non-zero load", {31'b0, calendar_set}, 32'h1);
    check_eq("R8 cleared by load", {31'b0, shadow_valid}, 32'h0);
    ticks(2); idle(1);
    check_eq("R3 midnight time", time_word, 32'h0000_0000);
    check_eq("R4 leap day 29", date_word, 32'h0000_2229);
    check_eq("R8 valid after two ticks", {31'b0, shadow_valid}, 32'h1);

    // R4 common-year February
    load(32'h0023_5959, 32'h0001_6228);
    ticks(2); idle(1);
    check_eq("R4 common Feb -> Mar 1", date_word, 32'h0001_8301);
    check_eq("R3 seconds after carry", time_word, 32'h0000_0001);

    // R5 year end rollover
    load(32'h0023_5959, 32'h0099_B231);
    ticks(1); idle(1); ticks(1); idle(1);
    check_eq("R5 2099 -> 2000", date_word, 32'h0000_C101);

    // R6 weekday 0 held, R4 30-day month
    load(32'h0023_5959, 32'h0024_0430);
    ticks(2); idle(1);
    check_eq("R6 weekday 0 held, Apr 30 -> May 1", date_word, 32'h0024_0501);

    // R4 31-day month
    load(32'h0023_5959, 32'h0023_4131);
    ticks(2); idle(1);
    check_eq("R4 Jan 31 -> Feb 1", date_word, 32'h0023_6201);

    // R3 minute and hour carries over a longer run with gaps
    load(32'h0010_5800, 32'h0021_2415);
    ticks(125); idle(1);
    check_eq("R3 10:58:00 + 125 s", time_word, 32'h0011_0005);
    for (int i = 0; i < 90; i++) step((i % 3) == 0, 0, 0, 0, '0, 0);
    idle(1);

    // R7 write outside init mode is ignored
    hold_t = time_word;
    step(0, 0, 1, 0, 32'h0012_3456, 0);
    step(0, 0, 0, 1, 32'h0055_2101, 0);
    idle(1);
    check_eq("R7 write outside init ignored", time_word, hold_t);
    check_eq("R7 flag kept", {31'b0, shadow_valid}, 32'h1);

    // R7 ticks in init mode do not advance
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, '0, 0);
    idle(1);
    check_eq("R7 frozen in init mode", time_word, hold_t);

    // R8 sync_clear freezes shadows until two ticks have passed
    step(0, 0, 0, 0, '0, 1);
    ticks(1);
    check_eq("R8 frozen after clear", time_word, hold_t);
    check_eq("R8 flag low after clear", {31'b0, shadow_valid}, 32'h0);
    ticks(1); idle(1);
    check_eq("R8 refreshed", {31'b0, shadow_valid}, 32'h1);

    // R9 all-zero load clears the status
    load(32'h0, 32'h0);
    check_eq("R9 cleared by zero load", {31'b0, calendar_set}, 32'h0);
    ticks(3); idle(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule